// File: doc/BRIEF.md
# Four-Channel Global Interrupt Aggregator

This block gathers the interrupt state of four serial channels into a few read-only global status registers. Each channel supplies a four-bit vector of pending sources that its own enable logic has already masked. A timer-timeout event and the channels' sleep states also come in. From these inputs the block keeps three registers up to date:

- a summary register with one bit per channel;
- a 12-bit field that holds a three-bit code for each channel's most urgent source;
- a wake-up flag, which is raised when the whole device leaves full sleep.

A single combined interrupt line is the OR of all of this state. Software reads the registers through a small read port with an address and a read strobe. A strobed read of the summary register acknowledges the wake-up flag.

The block keeps no history of its own for the channel sources. The summary and code registers follow the channel inputs with one register stage of delay. A channel's bit therefore drops only once that channel's own status registers have been serviced. Only the wake-up flag holds its value until it is acknowledged.

Top module: `irq_agg_top`

## Requirements
- R1: Offset 0 reads the summary register. Bit N is 1 one cycle after channel N has any pending source, and for channel 0 also a pending timer event. Bits 7:4 always read 0.
- R2: After reset every register at offsets 0 to 3 reads 0x00 and `irqOut` is low.
- R3: A channel's code is taken from its source vector. Bit 0 is line status (code 1) and has the highest priority. Bit 1 is receive (code 2), bit 2 is transmit-empty (code 3) and bit 3 is modem status (code 4). A timer event has the lowest priority and gives code 7. Code 0 means nothing is pending.
- R4: The timer event affects only channel 0. Channels 1 to 3 never report code 7.
- R5: Channel c's code occupies bits [3c+2:3c] of the 12-bit field. Offset 1 reads field bits 7:0. Offset 2 reads {4'b0, field bits 11:8}.
- R6: Offset 3 always reads 0x00.
- R7: The wake-up flag sets one cycle after the clock edge at which all four `chanAsleep` bits go from all ones (at the previous edge) to not all ones. Leaving sleep when fewer than four channels were asleep sets nothing.
- R8: A strobed read at offset 0 clears the wake-up flag. A strobed read at any other offset leaves it unchanged. If the flag is set and cleared in the same cycle, the set wins.
- R9: `irqOut` is high exactly when a summary bit or the wake-up flag is set.
- R10: A summary bit and its code return to 0 one cycle after that channel's sources (and, for channel 0, the timer) go inactive. Nothing is latched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chanSrc | input | 16 | Masked pending sources; channel c in bits [4c+3:4c] |
| timerEvt | input | 1 | Timer-timeout pending (reported on channel 0) |
| chanAsleep | input | 4 | Per-channel sleep state |
| rdEn | input | 1 | Read strobe (acknowledges wake-up at offset 0) |
| rdAddr | input | 2 | Register offset |
| rdData | output | 8 | Read data, from registered state |
| irqOut | output | 1 | Combined interrupt request |

## Verification
Every status result is due one clock edge after its stimulus: the summary bits, the codes, the wake-up flag and its clear, and therefore `irqOut`. The read data is a combinational view of that registered state and adds no cycle. The bench drives inputs on the falling edge and lets exactly one rising edge pass. Before the next rising edge it sweeps all four offsets with the strobe low, so a peek can never acknowledge the wake-up flag. A reference model updates at the same rising edge, using the same inputs that the design sampled.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  parameter int unsigned NUM_CH = 4;
  parameter int unsigned SRC_W  = 4;
  parameter int unsigned CODE_W = 3;
  parameter int unsigned DATA_W = 8;
  parameter int unsigned ADDR_W = 2;

  localparam int unsigned SRC_BITS  = NUM_CH * SRC_W;
  localparam int unsigned CODE_BITS = NUM_CH * CODE_W;
  localparam int unsigned WIDE_BITS = 2 * DATA_W;

  // source bit positions inside one channel's vector
  localparam int unsigned SRC_LINE  = 0;
  localparam int unsigned SRC_RX    = 1;
  localparam int unsigned SRC_TX    = 2;
  localparam int unsigned SRC_MODEM = 3;

  localparam logic [ADDR_W-1:0] ADDR_SUM     = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CODE_LO = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CODE_HI = 2'd2;

  typedef enum logic [CODE_W-1:0] {
    CODE_NONE  = 3'd0,
    CODE_LINE  = 3'd1,
    CODE_RX    = 3'd2,
    CODE_TX    = 3'd3,
    CODE_MODEM = 3'd4,
    CODE_TIMER = 3'd7
  } srcCode_e;

  typedef struct packed {
    logic setWake;
    logic clrWake;
    logic selSum;
    logic selLo;
    logic selHi;
  } ctlStrobe_t;
endpackage

// File: rtl/irq_agg_control.sv
module irq_agg_control
  import irq_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chanAsleep,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output ctlStrobe_t        strobe
);
  logic allAsleep;
  logic prevAllAsleep;

  assign allAsleep = &chanAsleep;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevAllAsleep <= 1'b0;
    else       prevAllAsleep <= allAsleep;
  end

  always_comb begin
    strobe         = '0;
    // wake only when the whole device had been asleep
    strobe.setWake = prevAllAsleep & ~allAsleep;
    strobe.selSum  = (rdAddr == ADDR_SUM);
    strobe.selLo   = (rdAddr == ADDR_CODE_LO);
    strobe.selHi   = (rdAddr == ADDR_CODE_HI);
    strobe.clrWake = rdEn & strobe.selSum;
  end
endmodule

// File: rtl/irq_agg_datapath.sv
module irq_agg_datapath
  import irq_agg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SRC_BITS-1:0]  chanSrc,
  input  logic                 timerEvt,
  input  ctlStrobe_t           strobe,
  output logic [DATA_W-1:0]    rdData,
  output logic                 irqOut,
  output logic [NUM_CH-1:0]    statSum,
  output logic [CODE_BITS-1:0] statCode,
  output logic                 wakeFlag
);
  logic [NUM_CH-1:0]    nxtSum;
  logic [CODE_BITS-1:0] nxtCode;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic [SRC_W-1:0] src;
    logic             chTmr;
    srcCode_e         code;

    assign src = chanSrc[c*SRC_W +: SRC_W];

    // only channel 0 carries the timer source
    if (c == 0) begin : g_tmr
      assign chTmr = timerEvt;
    end else begin : g_noTmr
      assign chTmr = 1'b0;
    end

    // lowest priority first, later lines override
    always_comb begin
      code = CODE_NONE;
      if (chTmr)          code = CODE_TIMER;
      if (src[SRC_MODEM]) code = CODE_MODEM;
      if (src[SRC_TX])    code = CODE_TX;
      if (src[SRC_RX])    code = CODE_RX;
      if (src[SRC_LINE])  code = CODE_LINE;
    end

    assign nxtSum[c]                   = (|src) | chTmr;
    assign nxtCode[c*CODE_W +: CODE_W] = code;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statSum  <= '0;
      statCode <= '0;
      wakeFlag <= 1'b0;
    end else begin
      statSum  <= nxtSum;
      statCode <= nxtCode;
      if (strobe.setWake)      wakeFlag <= 1'b1;
      else if (strobe.clrWake) wakeFlag <= 1'b0;
    end
  end

  logic [WIDE_BITS-1:0] codeWide;
  logic [DATA_W-1:0]    sumWide;

  assign codeWide = {{(WIDE_BITS-CODE_BITS){1'b0}}, statCode};
  assign sumWide  = {{(DATA_W-NUM_CH){1'b0}}, statSum};

  always_comb begin
    if (strobe.selSum)     rdData = sumWide;
    else if (strobe.selLo) rdData = codeWide[DATA_W-1:0];
    else if (strobe.selHi) rdData = codeWide[WIDE_BITS-1:DATA_W];
    else                   rdData = '0;
  end

  assign irqOut = (|statSum) | wakeFlag;
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [SRC_BITS-1:0] chanSrc,
  input  logic                timerEvt,
  input  logic [NUM_CH-1:0]   chanAsleep,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [DATA_W-1:0]   rdData,
  output logic                irqOut
);
  ctlStrobe_t           strobe;
  logic [NUM_CH-1:0]    statSum;
  logic [CODE_BITS-1:0] statCode;
  logic                 wakeFlag;

  irq_agg_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .chanAsleep (chanAsleep),
    .rdEn       (rdEn),
    .rdAddr     (rdAddr),
    .strobe     (strobe)
  );

  irq_agg_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .chanSrc  (chanSrc),
    .timerEvt (timerEvt),
    .strobe   (strobe),
    .rdData   (rdData),
    .irqOut   (irqOut),
    .statSum  (statSum),
    .statCode (statCode),
    .wakeFlag (wakeFlag)
  );
endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker
  import irq_agg_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic [SRC_BITS-1:0]  chanSrc,
  input logic                 timerEvt,
  input logic [NUM_CH-1:0]    chanAsleep,
  input logic                 rdEn,
  input logic [ADDR_W-1:0]    rdAddr,
  input logic [DATA_W-1:0]    rdData,
  input logic [NUM_CH-1:0]    statSum,
  input logic [CODE_BITS-1:0] statCode,
  input logic                 wakeFlag
);
  logic armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // R1: upper summary bits stay zero
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == ADDR_SUM) |-> (rdData[DATA_W-1:NUM_CH] == '0));

  // R6: reserved offset
  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == 2'd3) |-> (rdData == '0));

  // R1: channel 0 summary follows inputs one cycle later
  a_r1_sum0_follows: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (statSum[0] == $past((|chanSrc[SRC_W-1:0]) | timerEvt)));

  // R7: all-asleep exit raises the wake flag
  a_r7_wake_set: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(&chanAsleep) && !(&chanAsleep)) |=> wakeFlag);

  // R8: summary read clears when no set competes
  a_r8_wake_clear: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && (rdAddr == ADDR_SUM) && !(armed && $past(&chanAsleep) && !(&chanAsleep)))
      |=> !wakeFlag);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R3: code zero exactly when the channel is idle
    a_r3_code_matches_sum: assert property (@(posedge clk) disable iff (!rstN)
      (statCode[c*CODE_W +: CODE_W] == '0) == !statSum[c]);
    if (c > 0) begin : g_noTmr
      // R4: timer code never on other channels
      a_r4_no_timer_code: assert property (@(posedge clk) disable iff (!rstN)
        statCode[c*CODE_W +: CODE_W] != CODE_TIMER);
    end
  end
endmodule

bind irq_agg_top irq_agg_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .chanSrc    (chanSrc),
  .timerEvt   (timerEvt),
  .chanAsleep (chanAsleep),
  .rdEn       (rdEn),
  .rdAddr     (rdAddr),
  .rdData     (rdData),
  .statSum    (statSum),
  .statCode   (statCode),
  .wakeFlag   (wakeFlag)
);

// File: tb/irq_agg_top_bench.sv
`timescale 1ns/1ps
module irq_agg_top_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] chanSrc;
  logic        timerEvt;
  logic [3:0]  chanAsleep;
  logic        rdEn;
  logic [1:0]  rdAddr;
  logic [7:0]  rdData;
  logic        irqOut;

  int checks = 0;
  int errors = 0;

  logic        prevAll = 1'b0;
  logic        wakeM   = 1'b0;
  logic [3:0]  sumM    = '0;
  logic [11:0] codeM   = '0;

  always #4 clk = ~clk;

  irq_agg_top u_irq_agg_top (
    .clk(clk), .rstN(rstN), .chanSrc(chanSrc), .timerEvt(timerEvt),
    .chanAsleep(chanAsleep), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdData), .irqOut(irqOut)
  );

  function automatic logic [2:0] expCode(logic [3:0] s, logic t, int ch);
    if (s[0]) return 3'd1;
    if (s[1]) return 3'd2;
    if (s[2]) return 3'd3;
    if (s[3]) return 3'd4;
    if (t && ch == 0) return 3'd7;
    return 3'd0;
  endfunction

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    rdAddr = a;
    #0.5;
    d = rdData;
  endtask

  task automatic checkAll();
    logic [7:0] d;
    peek(2'd0, d); chk("R1 summary", {8'h0, d}, {12'h0, sumM});
    peek(2'd1, d); chk("R5 code low", {8'h0, d}, {8'h0, codeM[7:0]});
    peek(2'd2, d); chk("R5 code high", {8'h0, d}, {12'h0, codeM[11:8]});
    peek(2'd3, d); chk("R6 reserved", {8'h0, d}, 16'h0);
    chk("R9 irqOut", {15'h0, irqOut}, {15'h0, (|sumM) | wakeM});
  endtask

  // inputs applied now; one rising edge; model updated; checks before next edge
  task automatic step(input logic [15:0] src, input logic tmr, input logic [3:0] slp,
                      input logic ren, input logic [1:0] addr);
    chanSrc = src; timerEvt = tmr; chanAsleep = slp; rdEn = ren; rdAddr = addr;
    @(posedge clk);
    if (prevAll && !(&slp))        wakeM = 1'b1;
    else if (ren && addr == 2'd0)  wakeM = 1'b0;
    prevAll = &slp;
    for (int c = 0; c < 4; c++) begin
      sumM[c] = (|src[c*4 +: 4]) | (c == 0 && tmr);
      codeM[c*3 +: 3] = expCode(src[c*4 +: 4], tmr, c);
    end
    @(negedge clk);
    rdEn = 1'b0;
    checkAll();
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5EED1234));
    rstN = 1'b0; chanSrc = '0; timerEvt = 1'b0; chanAsleep = 4'hF;
    rdEn = 1'b0; rdAddr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R2: reset state before any active edge
    for (int a = 0; a < 4; a++) begin
      peek(a[1:0], d); chk("R2 reset reg", {8'h0, d}, 16'h0);
    end
    chk("R2 reset irqOut", {15'h0, irqOut}, 16'h0);

    // R3/R5: mixed priorities per channel
    step(16'hF8CA, 1'b0, 4'h0, 1'b0, 2'd0);
    peek(2'd1, d); chk("R3 R5 packed low", {8'h0, d}, 16'h001A);
    peek(2'd2, d); chk("R3 R5 packed high", {8'h0, d}, 16'h0003);
    // R4: timer alone -> channel 0 code 7 only
    step(16'h0000, 1'b1, 4'h0, 1'b0, 2'd0);
    peek(2'd1, d); chk("R4 timer code", {8'h0, d}, 16'h0007);
    peek(2'd0, d); chk("R4 timer summary", {8'h0, d}, 16'h0001);
    // R3: timer below line status on channel 0
    step(16'h0001, 1'b1, 4'h0, 1'b0, 2'd0);
    peek(2'd1, d); chk("R3 line over timer", {8'h0, d}, 16'h0001);
    // R10: everything released
    step(16'h0000, 1'b0, 4'h0, 1'b0, 2'd0);
    peek(2'd0, d); chk("R10 summary clear", {8'h0, d}, 16'h0);
    chk("R10 irqOut low", {15'h0, irqOut}, 16'h0);
    // R7: partial sleep exit does not wake
    step(16'h0000, 1'b0, 4'h7, 1'b0, 2'd0);
    step(16'h0000, 1'b0, 4'h0, 1'b0, 2'd0);
    chk("R7 no wake partial", {15'h0, irqOut}, 16'h0);
    // R7: full sleep then exit
    step(16'h0000, 1'b0, 4'hF, 1'b0, 2'd0);
    step(16'h0000, 1'b0, 4'h7, 1'b0, 2'd0);
    chk("R7 wake raised", {15'h0, irqOut}, 16'h1);
    // R8: other offsets do not clear, offset 0 does
    step(16'h0000, 1'b0, 4'h7, 1'b1, 2'd1);
    step(16'h0000, 1'b0, 4'h7, 1'b1, 2'd2);
    chk("R8 other read keeps", {15'h0, irqOut}, 16'h1);
    step(16'h0000, 1'b0, 4'h7, 1'b1, 2'd0);
    chk("R8 summary read clears", {15'h0, irqOut}, 16'h0);
    // R8: set wins over clear
    step(16'h0000, 1'b0, 4'hF, 1'b0, 2'd0);
    step(16'h0000, 1'b0, 4'h0, 1'b1, 2'd0);
    chk("R8 set wins", {15'h1 & 15'h0, irqOut}, 16'h1);
    step(16'h0000, 1'b0, 4'h0, 1'b1, 2'd0);
    chk("R8 cleared after", {15'h0, irqOut}, 16'h0);

    // random mix
    for (int i = 0; i < 500; i++) begin
      logic [15:0] s;
      logic [3:0]  sl;
      s  = 16'($urandom) & 16'($urandom);
      sl = ($urandom % 3 == 0) ? 4'hF : 4'($urandom);
      step(s, 1'($urandom % 2), sl, ($urandom % 4 == 0), 2'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule